// File: doc/BRIEF.md
# Keyed Configuration Register Port

This block is the setup front end of a peripheral-combo controller that hangs off a byte-wide host I/O bus. Two adjacent I/O addresses form its only window: a key/index port at a fixed address and a data port one address above it. The block stays locked until the host writes an unlock key to the key/index port. While unlocked, the host writes a register number to the key/index port and then reads or writes that register through the data port. A lock key written to the key/index port closes the window again.

The register space is flat and packs the settings of three functions: a parallel port and two serial ports. It holds one power byte for the parallel port, one power byte shared by the serial ports, a base byte per function, a DMA select byte and two interrupt select bytes. From the power bits and the base bytes the block decodes one chip-select per function, directly from the live host address and strobes. The interrupt and DMA selects are presented as plain nibble outputs for the functions to use.

The host side is a strobe bus with no back-pressure. Every read or write strobe completes in the cycle it is presented, so there is no ready signal. Writes take effect at the next rising edge, and read data is combinational from the current state.

Top module: `keyed_cfg_port`

## Requirements
- R1: After a synchronous reset the block is locked, the index is 0x00, every stored register is 0x00, all select outputs are 0 and no chip-select asserts.
- R2: Writing 0x55 to the key/index port (address CFG_ADDR, default 0x2E) unlocks the block from the next cycle. Writing 0xAA there locks it from the next cycle. While locked, reads of the key/index port and of the data port (CFG_ADDR+1) return 0xFF.
- R3: While the block is locked, writes to the data port and writes of any byte other than 0x55 to the key/index port change neither the registers nor the index.
- R4: While unlocked, any byte other than 0xAA written to the key/index port, 0x55 included, becomes the index, and reading the key/index port returns it. A write of 0xAA locks the block and leaves the index unchanged, so index 0xAA is unreachable.
- R5: While unlocked, the data port reads and writes all 8 bits of the register selected by the index, for indexes 0x01, 0x02, 0x23, 0x24, 0x25, 0x26, 0x27 and 0x28.
- R6: While unlocked, reading the data port at any other index returns 0x00, and writes at such an index are discarded.
- R7: Registers 0x23, 0x24 and 0x25 hold host address bits [9:2] of the parallel, serial-1 and serial-2 bases. A function decodes host address A when A < 0x400 and base*4 <= A <= base*4+7.
- R8: A function's chip-select can assert only when its power bit is 1 and its base byte is nonzero. The power bits are bit 2 of 0x01 (parallel), bit 3 of 0x02 (serial 1) and bit 7 of 0x02 (serial 2).
- R9: Chip-selects are combinational and assert only while the read strobe or the write strobe is high.
- R10: The parallel DMA select output equals bits [3:0] of 0x26, and the upper nibble of 0x26 is stored and read back. The parallel IRQ output equals bits [3:0] of 0x27. The serial-1 IRQ output equals bits [7:4] of 0x28, and the serial-2 IRQ output equals bits [3:0] of 0x28.
- R11: A data-port write changes the decode from the next cycle on. In the write cycle itself the chip-selects still follow the old settings.
- R12: io_rdata is 0xFF for every address other than the two configuration ports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | ADDR_W (16) | Host I/O address |
| io_rd | input | 1 | Host read strobe |
| io_wr | input | 1 | Host write strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Read data for the configuration ports |
| cs_par | output | 1 | Parallel port chip-select |
| cs_ser1 | output | 1 | Serial port 1 chip-select |
| cs_ser2 | output | 1 | Serial port 2 chip-select |
| par_dma_sel | output | 4 | Parallel port DMA channel select |
| par_irq_sel | output | 4 | Parallel port IRQ select |
| ser1_irq_sel | output | 4 | Serial port 1 IRQ select |
| ser2_irq_sel | output | 4 | Serial port 2 IRQ select |

## Verification
Two functions can act in the same cycle: a configuration access and a function decode. This happens when a function's base window covers the configuration ports, and the data-port write then also changes that same function's base. The bench places serial port 2 over 0x2C..0x33 and then writes a new base through the data port. In the write cycle it expects the chip-select still asserted from the old base. From the next cycle it expects the decode to move to the new window. Sweeps over every index and over the whole 10-bit address space, with the strobes toggling, judge the rest against arithmetic models.

// File: rtl/keyed_cfg_pkg.sv
package keyed_cfg_pkg;

  localparam int NFUNC = 3;
  localparam int NREG  = 8;
  localparam int SLOT_W = $clog2(NREG);

  typedef enum logic [1:0] {
    FN_PAR  = 2'd0,
    FN_SER1 = 2'd1,
    FN_SER2 = 2'd2
  } fn_e;

  // register numbers seen by the host
  localparam logic [7:0] IX_PWR_PAR = 8'h01;
  localparam logic [7:0] IX_PWR_SER = 8'h02;
  localparam logic [7:0] IX_BASE_PAR = 8'h23;
  localparam logic [7:0] IX_BASE_S1 = 8'h24;
  localparam logic [7:0] IX_BASE_S2 = 8'h25;
  localparam logic [7:0] IX_DMA_PAR = 8'h26;
  localparam logic [7:0] IX_IRQ_PAR = 8'h27;
  localparam logic [7:0] IX_IRQ_SER = 8'h28;

  // storage slots
  localparam int SL_PWR_PAR = 0;
  localparam int SL_PWR_SER = 1;
  localparam int SL_BASE0   = 2;
  localparam int SL_DMA_PAR = 5;
  localparam int SL_IRQ_PAR = 6;
  localparam int SL_IRQ_SER = 7;

  // power bit positions inside their bytes
  localparam int PB_PAR  = 2;
  localparam int PB_SER1 = 3;
  localparam int PB_SER2 = 7;

  typedef struct packed {
    logic              hit;
    logic [SLOT_W-1:0] slot;
  } slot_t;

  function automatic slot_t slot_of(input logic [7:0] ix);
    slot_t s;
    s.hit = 1'b1;
    case (ix)
      IX_PWR_PAR:  s.slot = SLOT_W'(SL_PWR_PAR);
      IX_PWR_SER:  s.slot = SLOT_W'(SL_PWR_SER);
      IX_BASE_PAR: s.slot = SLOT_W'(SL_BASE0 + 0);
      IX_BASE_S1:  s.slot = SLOT_W'(SL_BASE0 + 1);
      IX_BASE_S2:  s.slot = SLOT_W'(SL_BASE0 + 2);
      IX_DMA_PAR:  s.slot = SLOT_W'(SL_DMA_PAR);
      IX_IRQ_PAR:  s.slot = SLOT_W'(SL_IRQ_PAR);
      IX_IRQ_SER:  s.slot = SLOT_W'(SL_IRQ_SER);
      default: begin
        s.hit  = 1'b0;
        s.slot = '0;
      end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/keyed_cfg_lock.sv
module keyed_cfg_lock #(
  parameter logic [7:0] KEY_ON  = 8'h55,
  parameter logic [7:0] KEY_OFF = 8'hAA
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       key_wr,
  input  logic [7:0] wdata,
  output logic       unlocked,
  output logic [7:0] index
);

  logic is_on, is_off;
  assign is_on  = (wdata == KEY_ON);
  assign is_off = (wdata == KEY_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked <= 1'b0;
    end else if (key_wr) begin
      if (is_off)
        unlocked <= 1'b0;
      else if (is_on)
        unlocked <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      index <= 8'h00;
    else if (key_wr && unlocked && !is_off)
      index <= wdata;
  end

  p_unlock_key_r2: assert property (@(posedge clk) disable iff (rst)
    key_wr && is_on |=> unlocked);
  p_lock_key_r2: assert property (@(posedge clk) disable iff (rst)
    key_wr && is_off |=> !unlocked);
  p_index_load_r4: assert property (@(posedge clk) disable iff (rst)
    key_wr && unlocked && !is_off |=> index == $past(wdata));
  p_index_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(key_wr && unlocked && !is_off) |=> $stable(index));
  p_locked_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !key_wr |=> $stable(unlocked));

endmodule

// File: rtl/keyed_cfg_regs.sv
module keyed_cfg_regs
  import keyed_cfg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  unlocked,
  input  logic [7:0]            index,
  input  logic                  data_wr,
  input  logic [7:0]            wdata,
  output logic [7:0]            rd_val,
  output logic [NFUNC-1:0]      fn_en,
  output logic [NFUNC-1:0][7:0] fn_base,
  output logic [3:0]            par_dma,
  output logic [3:0]            par_irq,
  output logic [3:0]            s1_irq,
  output logic [3:0]            s2_irq
);

  logic [NREG-1:0][7:0] regs;
  slot_t                sel;
  logic                 wr_go;

  assign sel   = slot_of(index);
  assign wr_go = unlocked && data_wr && sel.hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '0;
    end else if (wr_go) begin
      for (int i = 0; i < NREG; i++)
        if (sel.slot == SLOT_W'(i))
          regs[i] <= wdata;
    end
  end

  always_comb begin
    rd_val = 8'h00;
    if (sel.hit)
      rd_val = regs[sel.slot];
  end

  for (genvar g = 0; g < NFUNC; g++) begin : g_base
    assign fn_base[g] = regs[SL_BASE0 + g];
  end

  assign fn_en[FN_PAR]  = regs[SL_PWR_PAR][PB_PAR];
  assign fn_en[FN_SER1] = regs[SL_PWR_SER][PB_SER1];
  assign fn_en[FN_SER2] = regs[SL_PWR_SER][PB_SER2];

  assign par_dma = regs[SL_DMA_PAR][3:0];
  assign par_irq = regs[SL_IRQ_PAR][3:0];
  assign s1_irq  = regs[SL_IRQ_SER][7:4];
  assign s2_irq  = regs[SL_IRQ_SER][3:0];

  p_locked_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    !unlocked |=> $stable(regs));
  p_unimpl_discard_r6: assert property (@(posedge clk) disable iff (rst)
    !sel.hit |=> $stable(regs));
  p_unimpl_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !sel.hit |-> rd_val == 8'h00);
  p_write_lands_r5: assert property (@(posedge clk) disable iff (rst)
    wr_go |=> rd_val == $past(wdata) || $past(index) != index);

endmodule

// File: rtl/keyed_cfg_decode.sv
module keyed_cfg_decode
  import keyed_cfg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WIN    = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  strobe,
  input  logic [NFUNC-1:0]      fn_en,
  input  logic [NFUNC-1:0][7:0] fn_base,
  output logic [NFUNC-1:0]      cs
);

  localparam int EXT = ADDR_W + 1;
  localparam int LEGACY_W = 10;

  logic [EXT-1:0] addr_x;
  logic           low_space;

  assign addr_x    = {1'b0, addr};
  assign low_space = (addr >> LEGACY_W) == '0;

  for (genvar g = 0; g < NFUNC; g++) begin : g_fn
    logic [EXT-1:0] lo, hi;
    logic           in_win, armed;
    assign lo     = EXT'({fn_base[g], 2'b00});
    assign hi     = lo + EXT'(WIN - 1);
    assign in_win = low_space && (addr_x >= lo) && (addr_x <= hi);
    assign armed  = fn_en[g] && (fn_base[g] != 8'h00);
    assign cs[g]  = strobe && armed && in_win;

    p_cs_needs_strobe_r9: assert property (@(posedge clk) disable iff (rst)
      !strobe |-> !cs[g]);
    p_cs_needs_power_r8: assert property (@(posedge clk) disable iff (rst)
      !fn_en[g] || fn_base[g] == 8'h00 |-> !cs[g]);
    p_cs_low_space_r7: assert property (@(posedge clk) disable iff (rst)
      !low_space |-> !cs[g]);
  end

endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import keyed_cfg_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [15:0]     CFG_ADDR = 16'h002E,
  parameter logic [7:0]      KEY_ON   = 8'h55,
  parameter logic [7:0]      KEY_OFF  = 8'hAA,
  parameter int              WIN      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              cs_par,
  output logic              cs_ser1,
  output logic              cs_ser2,
  output logic [3:0]        par_dma_sel,
  output logic [3:0]        par_irq_sel,
  output logic [3:0]        ser1_irq_sel,
  output logic [3:0]        ser2_irq_sel
);

  localparam logic [ADDR_W-1:0] KEY_PORT  = ADDR_W'(CFG_ADDR);
  localparam logic [ADDR_W-1:0] DATA_PORT = ADDR_W'(CFG_ADDR) + ADDR_W'(1);

  logic                  key_hit, data_hit;
  logic                  unlocked;
  logic [7:0]            index;
  logic [7:0]            rd_val;
  logic [NFUNC-1:0]      fn_en;
  logic [NFUNC-1:0][7:0] fn_base;
  logic [NFUNC-1:0]      cs;

  assign key_hit  = (io_addr == KEY_PORT);
  assign data_hit = (io_addr == DATA_PORT);

  keyed_cfg_lock #(.KEY_ON(KEY_ON), .KEY_OFF(KEY_OFF)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .key_wr   (io_wr && key_hit),
    .wdata    (io_wdata),
    .unlocked (unlocked),
    .index    (index)
  );

  keyed_cfg_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .unlocked (unlocked),
    .index    (index),
    .data_wr  (io_wr && data_hit),
    .wdata    (io_wdata),
    .rd_val   (rd_val),
    .fn_en    (fn_en),
    .fn_base  (fn_base),
    .par_dma  (par_dma_sel),
    .par_irq  (par_irq_sel),
    .s1_irq   (ser1_irq_sel),
    .s2_irq   (ser2_irq_sel)
  );

  keyed_cfg_decode #(.ADDR_W(ADDR_W), .WIN(WIN)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .addr    (io_addr),
    .strobe  (io_rd || io_wr),
    .fn_en   (fn_en),
    .fn_base (fn_base),
    .cs      (cs)
  );

  assign cs_par  = cs[FN_PAR];
  assign cs_ser1 = cs[FN_SER1];
  assign cs_ser2 = cs[FN_SER2];

  always_comb begin
    io_rdata = 8'hFF;
    if (unlocked) begin
      if (key_hit)
        io_rdata = index;
      else if (data_hit)
        io_rdata = rd_val;
    end
  end

  p_locked_reads_ff_r2: assert property (@(posedge clk) disable iff (rst)
    !unlocked && (key_hit || data_hit) |-> io_rdata == 8'hFF);
  p_other_addr_ff_r12: assert property (@(posedge clk) disable iff (rst)
    !key_hit && !data_hit |-> io_rdata == 8'hFF);
  p_index_readback_r4: assert property (@(posedge clk) disable iff (rst)
    unlocked && key_hit |-> io_rdata == index);

endmodule

// File: tb/sim_keyed_cfg_port.sv
module sim_keyed_cfg_port;

  localparam int KP = 'h2E;
  localparam int DP = 'h2F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        cs_par, cs_ser1, cs_ser2;
  logic [3:0]  par_dma_sel, par_irq_sel, ser1_irq_sel, ser2_irq_sel;

  int nchk = 0, nerr = 0;
  logic [7:0] m [256];
  logic [7:0] rv;

  always #5 clk = ~clk;

  keyed_cfg_port u0 (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cs_par(cs_par),
    .cs_ser1(cs_ser1), .cs_ser2(cs_ser2), .par_dma_sel(par_dma_sel),
    .par_irq_sel(par_irq_sel), .ser1_irq_sel(ser1_irq_sel),
    .ser2_irq_sel(ser2_irq_sel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit impl(input int i);
    return i == 'h01 || i == 'h02 || (i >= 'h23 && i <= 'h28);
  endfunction

  function automatic bit cs_model(input int a, input int b, input bit pw, input bit stb);
    return stb && pw && b != 0 && a < 1024 && a >= b * 4 && a <= b * 4 + 7;
  endfunction

  task automatic bwr(input int a, input logic [7:0] d);
    @(negedge clk);
    io_addr = 16'(a); io_wdata = d; io_wr = 1'b1;
    @(posedge clk);
    #1 io_wr = 1'b0;
  endtask

  task automatic brd(input int a, output logic [7:0] d);
    @(negedge clk);
    io_addr = 16'(a); io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic setreg(input int ix, input logic [7:0] v);
    bwr(KP, 8'(ix));
    bwr(DP, v);
    if (impl(ix)) m[ix] = v;
  endtask

  task automatic sweep(input string tag);
    bit p0, p1, p2;
    p0 = m['h01][2]; p1 = m['h02][3]; p2 = m['h02][7];
    for (int a = 0; a < 1040; a++) begin
      bit stb;
      stb = (a % 3) != 0;
      @(negedge clk);
      io_addr = 16'(a); io_rd = stb;
      #1;
      check({"R7 R8 R9 par ", tag}, {a, 15'd0, cs_par},
            {a, 15'd0, cs_model(a, int'(m['h23]), p0, stb)});
      check({"R7 R8 R9 ser1 ", tag}, {a, 15'd0, cs_ser1},
            {a, 15'd0, cs_model(a, int'(m['h24]), p1, stb)});
      check({"R7 R8 R9 ser2 ", tag}, {a, 15'd0, cs_ser2},
            {a, 15'd0, cs_model(a, int'(m['h25]), p2, stb)});
    end
    io_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) m[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    brd(KP, rv); check("R1 locked read key port", rv, 8'hFF);
    check("R1 selects zero", {par_dma_sel, par_irq_sel, ser1_irq_sel, ser2_irq_sel}, 16'h0);
    sweep("reset");
    bwr(KP, 8'h55);
    brd(KP, rv); check("R1 index cleared", rv, 8'h00);
    for (int i = 0; i < 256; i++) begin
      if (i == 'hAA) continue;
      bwr(KP, 8'(i));
      brd(DP, rv); check("R1 regs zero", {i, rv}, {i, 8'h00});
    end

    // R4 R5 R6: exhaustive write then read over every reachable index
    for (int i = 0; i < 256; i++) begin
      if (i == 'hAA) continue;
      setreg(i, 8'((i * 7 + 3) & 255));
      brd(KP, rv); check("R4 index readback", {i, rv}, {i, 8'(i)});
    end
    for (int i = 0; i < 256; i++) begin
      if (i == 'hAA) continue;
      bwr(KP, 8'(i));
      brd(DP, rv);
      check(impl(i) ? "R5 register readback" : "R6 unimplemented reads zero",
            {i, rv}, {i, m[i]});
    end

    // R10: select outputs and stored upper nibble
    setreg('h26, 8'hA5); setreg('h27, 8'h3C); setreg('h28, 8'h9E);
    check("R10 par dma", par_dma_sel, 4'h5);
    check("R10 par irq", par_irq_sel, 4'hC);
    check("R10 ser1 irq", ser1_irq_sel, 4'h9);
    check("R10 ser2 irq", ser2_irq_sel, 4'hE);
    bwr(KP, 8'h26); brd(DP, rv); check("R10 upper nibble kept", rv, 8'hA5);

    // R12: other addresses read 0xFF
    brd('h2D, rv); check("R12 below key port", rv, 8'hFF);
    brd('h30, rv); check("R12 above data port", rv, 8'hFF);
    brd('h102E, rv); check("R12 aliased high address", rv, 8'hFF);

    // R4: 0x55 becomes an index when unlocked; 0xAA locks and keeps index
    bwr(KP, 8'h55); brd(KP, rv); check("R4 0x55 as index", rv, 8'h55);
    bwr(KP, 8'h27); bwr(KP, 8'hAA);
    brd(KP, rv); check("R2 locked after 0xAA", rv, 8'hFF);
    brd(DP, rv); check("R2 locked data port", rv, 8'hFF);

    // R3: locked writes ignored
    bwr(DP, 8'h11); bwr(KP, 8'h12); bwr(KP, 8'hAA);
    bwr(KP, 8'h55);
    brd(KP, rv); check("R4 R3 index kept across lock", rv, 8'h27);
    brd(DP, rv); check("R3 register untouched", rv, 8'h3C);

    // decode scenarios
    setreg('h01, 8'h00); setreg('h02, 8'h00);
    setreg('h23, 8'h00); setreg('h24, 8'h00); setreg('h25, 8'h00);
    setreg('h01, 8'h04); setreg('h02, 8'h88);
    sweep("powered zero base");
    setreg('h23, 8'h9E); setreg('h24, 8'hFE); setreg('h25, 8'hBE);
    sweep("powered typical");
    setreg('h01, 8'hFB); setreg('h02, 8'h77);
    sweep("unpowered");
    setreg('h01, 8'h04); setreg('h02, 8'h88);
    setreg('h23, 8'hFF); setreg('h24, 8'h01); setreg('h25, 8'h0B);
    sweep("edge bases");

    // R11: same-cycle config access and decode (ser2 window 0x2C..0x33)
    bwr(KP, 8'h25);
    @(negedge clk);
    io_addr = 16'(DP); io_wdata = 8'h20; io_wr = 1'b1;
    #1 check("R11 cs during write uses old base", cs_ser2, 1'b1);
    @(posedge clk);
    #1 io_wr = 1'b0; m['h25] = 8'h20;
    @(negedge clk); io_addr = 16'(DP); io_rd = 1'b1;
    #1 check("R11 old window dropped", cs_ser2, 1'b0);
    io_addr = 16'h0080;
    #1 check("R11 new window live", cs_ser2, 1'b1);
    io_addr = 16'h0087;
    #1 check("R7 last byte of window", cs_ser2, 1'b1);
    io_addr = 16'h0088;
    #1 check("R7 past window", cs_ser2, 1'b0);
    io_rd = 1'b0;
    #1 check("R9 no strobe", cs_ser2, 1'b0);
    sweep("after move");

    // R1: reset again clears everything
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    for (int i = 0; i < 256; i++) m[i] = 8'h00;
    brd(KP, rv); check("R1 relocked by reset", rv, 8'hFF);
    check("R1 selects cleared", {par_dma_sel, par_irq_sel, ser1_irq_sel, ser2_irq_sel}, 16'h0);
    sweep("post reset");

    finish_run();
  end

endmodule